// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR-style network DRAM. It brings the memory from reset to normal operation. After reset it keeps the device's power-down pin low and waits with the clock running until a stabilization time has passed. That time is given in microseconds and converted to cycles from the clock frequency. The sequencer then raises the power-down pin, waits out the power-down exit delay, and programs the extended mode register, which holds DLL enable, driver strength and strobe type. It then programs the mode register, which holds CAS latency, burst type and burst length, and issues a configurable number of auto-refresh commands.

Deselect fills every cycle in which no command is issued. The two op-codes come from static input ports and are captured while the stabilization wait runs. The ready flag rises once two conditions both hold: the refresh cycle time of the last refresh has elapsed, and the DLL lock interval, counted from the extended mode register command, has passed. From then on the normal controller takes the command bus. The data bus output enable stays low throughout.

Top module: `pwrup_seq`

## Requirements
- R1: While reset is asserted, `pwr_en_o` is 0, `cmd_o` is deselect, `addr_o` is 0 and `ready_o` is 0.
- R2: Let reset be released and call the cycle before the first rising edge cycle 0. `pwr_en_o` stays 0 and `cmd_o` stays deselect through cycle S-1, where S = CLK_MHZ*STAB_US. `pwr_en_o` is 1 from cycle S on.
- R3: The extended mode register command (`cmd_o` = 1) appears for exactly one cycle, at cycle E = S+PDEX_CYC. It carries the captured extended op-code on `addr_o`.
- R4: The mode register command (`cmd_o` = 2) appears for one cycle, at cycle E+RSC_CYC. It carries the captured mode op-code on `addr_o`.
- R5: Exactly NUM_REF auto-refresh commands (`cmd_o` = 3) are issued. The first is at cycle E+2*RSC_CYC and each later one follows RFC_CYC cycles after the one before.
- R6: In every cycle with no command, `cmd_o` is deselect (0) and `addr_o` is 0. The command codes are: deselect 0, extended mode register set 1, mode register set 2, auto-refresh 3.
- R7: `ready_o` rises at cycle max(E+2*RSC_CYC+NUM_REF*RFC_CYC, E+LOCK_CYC) and stays high. No command other than deselect is issued once it is high.
- R8: `dq_oe_o` is 0 in every cycle.
- R9: The op-codes used are the values on `emr_op_i` and `mr_op_i` in cycle S-1. Changes made from cycle S on have no effect.
- R10: Asserting reset at any point returns all outputs to the R1 state at once, without waiting for a clock edge. A later release restarts the whole sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emr_op_i | input | OP_W | Extended mode register op-code (static) |
| mr_op_i | input | OP_W | Mode register op-code (static) |
| cmd_o | output | 3 | Command to the memory |
| addr_o | output | OP_W | Address / op-code bus |
| pwr_en_o | output | 1 | Power-down pin, low keeps the device powered down |
| ready_o | output | 1 | Initialization finished |
| dq_oe_o | output | 1 | Data bus output enable |

## Verification
Two instances run side by side. In one the lock interval outlasts the refresh phase. In the other the refresh phase outlasts the lock interval. Together they show whether ready is gated by both conditions or only by one. Random op-codes are loaded before reset and changed once inside the stabilization wait and once after it. This shows whether the value captured at the end of the wait reaches the address bus or whether a stale or late value does. Resets are asserted at random points of the sequence, and each is followed by a full run, to show that every counter restarts cleanly.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [2:0] {
        CMD_DESL = 3'd0,
        CMD_EMRS = 3'd1,
        CMD_MRS  = 3'd2,
        CMD_REF  = 3'd3
    } mem_cmd_e;

    typedef enum logic [2:0] {
        PH_STAB,
        PH_PDEX,
        PH_EMR,
        PH_MR,
        PH_REF,
        PH_LOCK,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/pwrup_timer.sv
// Loadable down-counter used for every timed phase of the sequence.
module pwrup_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= W'(RST_VAL);
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwrup_lock.sv
// Counts the DLL lock interval from the extended mode command.
// ok_o high in cycle c means cycle c+1 lies at least LOCK_CYC cycles after it.
module pwrup_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic ok_o
);
    localparam int LW = $clog2(LOCK_CYC + 1);
    localparam logic [LW-1:0] LAST = LW'(LOCK_CYC - 1);

    logic [LW-1:0] lk_d, lk_q;
    logic          run_d, run_q;

    always_comb begin
        lk_d  = lk_q;
        run_d = run_q;
        if (start_i) begin
            lk_d  = '0;
            run_d = 1'b1;
        end else if (run_q && lk_q != LAST) begin
            lk_d = lk_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lk_q  <= '0;
            run_q <= 1'b0;
        end else begin
            lk_q  <= lk_d;
            run_q <= run_d;
        end
    end

    assign ok_o = run_q && (lk_q == LAST);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int STAB_US  = 200,
    parameter int PDEX_CYC = 4,
    parameter int RSC_CYC  = 2,
    parameter int RFC_CYC  = 20,
    parameter int LOCK_CYC = 200,
    parameter int NUM_REF  = 2,
    parameter int OP_W     = 15
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [OP_W-1:0] emr_op_i,
    input  logic [OP_W-1:0] mr_op_i,
    output logic [2:0]      cmd_o,
    output logic [OP_W-1:0] addr_o,
    output logic            pwr_en_o,
    output logic            ready_o,
    output logic            dq_oe_o
);
    localparam int STAB_CYC = CLK_MHZ * STAB_US;
    localparam int MAX_A    = (STAB_CYC > PDEX_CYC) ? STAB_CYC : PDEX_CYC;
    localparam int MAX_B    = (RSC_CYC > RFC_CYC) ? RSC_CYC : RFC_CYC;
    localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam int RW       = $clog2(NUM_REF + 1);

    typedef struct packed {
        phase_e          ph;
        mem_cmd_e        cmd;
        logic [OP_W-1:0] addr;
        logic            pd;
        logic            rdy;
        logic [RW-1:0]   refs;
        logic [OP_W-1:0] emr;
        logic [OP_W-1:0] mr;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          lock_start;
    logic          lock_ok;

    pwrup_timer #(
        .W       (CW),
        .RST_VAL (STAB_CYC - 1)
    ) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pwrup_lock #(
        .LOCK_CYC (LOCK_CYC)
    ) i_lock (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (lock_start),
        .ok_o    (lock_ok)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cmd    = CMD_DESL;
        s_d.addr   = '0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        lock_start = 1'b0;
        unique case (s_q.ph)
            PH_STAB: begin
                s_d.emr = emr_op_i;
                s_d.mr  = mr_op_i;
                if (tmr_zero) begin
                    s_d.ph   = PH_PDEX;
                    s_d.pd   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(PDEX_CYC - 1);
                end
            end
            PH_PDEX: begin
                if (tmr_zero) begin
                    s_d.ph     = PH_EMR;
                    s_d.cmd    = CMD_EMRS;
                    s_d.addr   = s_q.emr;
                    tmr_load   = 1'b1;
                    tmr_val    = CW'(RSC_CYC - 1);
                    lock_start = 1'b1;
                end
            end
            PH_EMR: begin
                if (tmr_zero) begin
                    s_d.ph   = PH_MR;
                    s_d.cmd  = CMD_MRS;
                    s_d.addr = s_q.mr;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RSC_CYC - 1);
                end
            end
            PH_MR: begin
                if (tmr_zero) begin
                    s_d.ph   = PH_REF;
                    s_d.cmd  = CMD_REF;
                    s_d.refs = RW'(1);
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RFC_CYC - 1);
                end
            end
            PH_REF: begin
                if (tmr_zero) begin
                    if (s_q.refs != RW'(NUM_REF)) begin
                        s_d.cmd  = CMD_REF;
                        s_d.refs = s_q.refs + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(RFC_CYC - 1);
                    end else if (lock_ok) begin
                        s_d.ph  = PH_RUN;
                        s_d.rdy = 1'b1;
                    end else begin
                        s_d.ph = PH_LOCK;
                    end
                end
            end
            PH_LOCK: begin
                if (lock_ok) begin
                    s_d.ph  = PH_RUN;
                    s_d.rdy = 1'b1;
                end
            end
            default: begin
                s_d.ph = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.ph   <= PH_STAB;
            s_q.cmd  <= CMD_DESL;
            s_q.addr <= '0;
            s_q.pd   <= 1'b0;
            s_q.rdy  <= 1'b0;
            s_q.refs <= '0;
            s_q.emr  <= '0;
            s_q.mr   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o    = s_q.cmd;
    assign addr_o   = s_q.addr;
    assign pwr_en_o = s_q.pd;
    assign ready_o  = s_q.rdy;
    assign dq_oe_o  = 1'b0;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int RSC_CYC  = 2,
    parameter int RFC_CYC  = 20,
    parameter int LOCK_CYC = 200,
    parameter int NUM_REF  = 2,
    parameter int OP_W     = 15
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [2:0]      cmd_o,
    input logic [OP_W-1:0] addr_o,
    input logic            pwr_en_o,
    input logic            ready_o
);
    localparam int GMAX = (RSC_CYC > RFC_CYC) ? RSC_CYC : RFC_CYC;
    localparam int GW   = $clog2(GMAX + 2);
    localparam int LKW  = $clog2(LOCK_CYC + 2);
    localparam int RW   = $clog2(NUM_REF + 2);

    logic [GW-1:0]  gap_q;
    logic [2:0]     last_q;
    logic [LKW-1:0] lk_q;
    logic           seen_q;
    logic [RW-1:0]  nref_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            last_q <= 3'd0;
            lk_q   <= '0;
            seen_q <= 1'b0;
            nref_q <= '0;
        end else begin
            if (cmd_o != 3'd0) begin
                gap_q  <= GW'(1);
                last_q <= cmd_o;
            end else if (gap_q != GW'(GMAX)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (cmd_o == 3'd1) begin
                lk_q   <= LKW'(1);
                seen_q <= 1'b1;
            end else if (seen_q && lk_q != LKW'(LOCK_CYC)) begin
                lk_q <= lk_q + 1'b1;
            end
            if (cmd_o == 3'd3 && nref_q != RW'(NUM_REF + 1)) begin
                nref_q <= nref_q + 1'b1;
            end
        end
    end

    assert_desl_while_pd_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_en_o |-> cmd_o == 3'd0);

    assert_pd_stays_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_en_o |=> pwr_en_o);

    assert_mrs_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == 3'd2 |-> (last_q == 3'd1 && gap_q >= GW'(RSC_CYC)));

    assert_ref_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == 3'd3 |-> gap_q >= ((last_q == 3'd3) ? GW'(RFC_CYC) : GW'(RSC_CYC)));

    assert_ref_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> nref_q == RW'(NUM_REF));

    assert_idle_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == 3'd0 |-> addr_o == '0);

    assert_ready_after_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (seen_q && lk_q >= LKW'(LOCK_CYC)));

    assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o);

    assert_quiet_after_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> cmd_o == 3'd0);
endmodule

bind pwrup_seq pwrup_seq_chk #(
    .RSC_CYC  (RSC_CYC),
    .RFC_CYC  (RFC_CYC),
    .LOCK_CYC (LOCK_CYC),
    .NUM_REF  (NUM_REF),
    .OP_W     (OP_W)
) i_pwrup_seq_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_o    (cmd_o),
    .addr_o   (addr_o),
    .pwr_en_o (pwr_en_o),
    .ready_o  (ready_o)
);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int STAB_US    = 200;
    localparam int S          = CLK_MHZ * STAB_US;
    localparam int OP_W       = 15;
    localparam int RUN_LEN    = 420;

    typedef struct {
        int pdex;
        int rsc;
        int rfc;
        int nref;
        int lock;
    } cfg_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] emr_op = '0;
    logic [OP_W-1:0] mr_op = '0;

    logic [2:0]      cmd_a, cmd_b;
    logic [OP_W-1:0] addr_a, addr_b;
    logic            pd_a, pd_b, rdy_a, rdy_b, oe_a, oe_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Lock interval dominates.
    pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .PDEX_CYC(3), .RSC_CYC(4),
        .RFC_CYC(12), .LOCK_CYC(200), .NUM_REF(3), .OP_W(OP_W)
    ) i_pwrup_seq (
        .clk_i(clk), .rst_ni(rst_n), .emr_op_i(emr_op), .mr_op_i(mr_op),
        .cmd_o(cmd_a), .addr_o(addr_a), .pwr_en_o(pd_a), .ready_o(rdy_a), .dq_oe_o(oe_a)
    );

    // Refresh phase dominates.
    pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .PDEX_CYC(2), .RSC_CYC(3),
        .RFC_CYC(9), .LOCK_CYC(20), .NUM_REF(4), .OP_W(OP_W)
    ) i_pwrup_seq_alt (
        .clk_i(clk), .rst_ni(rst_n), .emr_op_i(emr_op), .mr_op_i(mr_op),
        .cmd_o(cmd_b), .addr_o(addr_b), .pwr_en_o(pd_b), .ready_o(rdy_b), .dq_oe_o(oe_b)
    );

    function automatic cfg_t cfg_a();
        cfg_t c;
        c.pdex = 3; c.rsc = 4; c.rfc = 12; c.nref = 3; c.lock = 200;
        return c;
    endfunction

    function automatic cfg_t cfg_b();
        cfg_t c;
        c.pdex = 2; c.rsc = 3; c.rfc = 9; c.nref = 4; c.lock = 20;
        return c;
    endfunction

    // Expected command, pin and ready level in cycle k, from the requirements.
    function automatic void model(input int k, input cfg_t c, output logic [2:0] cmd,
                                  output logic pd, output logic rdy, output string tag);
        int e, f, r;
        e = S + c.pdex;
        f = e + 2 * c.rsc + c.nref * c.rfc;
        r = (f > e + c.lock) ? f : e + c.lock;
        cmd = 3'd0;
        pd  = (k >= S);
        rdy = (k >= r);
        tag = (k < S) ? "R2" : (rdy ? "R7" : "R6");
        if (k == e) begin
            cmd = 3'd1; tag = "R3";
        end else if (k == e + c.rsc) begin
            cmd = 3'd2; tag = "R4";
        end else begin
            for (int i = 0; i < c.nref; i++) begin
                if (k == e + 2 * c.rsc + i * c.rfc) begin
                    cmd = 3'd3; tag = "R5";
                end
            end
        end
    endfunction

    task automatic check_one(input string name, input int k, input cfg_t c,
                             input logic [2:0] cmd, input logic [OP_W-1:0] addr,
                             input logic pd, input logic rdy, input logic oe,
                             input logic [OP_W-1:0] exp_emr, input logic [OP_W-1:0] exp_mr);
        logic [2:0]      e_cmd;
        logic            e_pd, e_rdy;
        logic [OP_W-1:0] e_addr;
        string           tag;
        model(k, c, e_cmd, e_pd, e_rdy, tag);
        e_addr = (e_cmd == 3'd1) ? exp_emr : ((e_cmd == 3'd2) ? exp_mr : '0);
        checks++;
        if (cmd !== e_cmd || pd !== e_pd || rdy !== e_rdy) begin
            errors++;
            $display("FAIL %s %s cycle %0d: cmd/pd/rdy %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, name, k, cmd, pd, rdy, e_cmd, e_pd, e_rdy);
        end
        checks++;
        if (addr !== e_addr) begin
            errors++;
            $display("FAIL %s %s cycle %0d: addr %h expected %h",
                     (e_cmd == 3'd0) ? "R6" : "R3,R4,R9", name, k, addr, e_addr);
        end
        checks++;
        if (oe !== 1'b0) begin
            errors++;
            $display("FAIL R8 %s cycle %0d: dq_oe %b expected 0", name, k, oe);
        end
    endtask

    task automatic check_reset(input string tag);
        checks++;
        if (cmd_a !== 3'd0 || addr_a !== '0 || pd_a !== 1'b0 || rdy_a !== 1'b0 ||
            cmd_b !== 3'd0 || addr_b !== '0 || pd_b !== 1'b0 || rdy_b !== 1'b0) begin
            errors++;
            $display("FAIL %s reset state: a %0d/%h/%b/%b b %0d/%h/%b/%b expected 0/0/0/0",
                     tag, cmd_a, addr_a, pd_a, rdy_a, cmd_b, addr_b, pd_b, rdy_b);
        end
    endtask

    // One power-up run; abort_at >= 0 asserts reset in that cycle (R10).
    task automatic run_seq(input int abort_at);
        logic [OP_W-1:0] fin_emr, fin_mr;
        int change_at;
        emr_op = OP_W'($urandom);
        mr_op  = OP_W'($urandom);
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        #1 check_reset("R1");
        change_at = int'($urandom_range(1, S - 2));
        fin_emr = OP_W'($urandom);
        fin_mr  = OP_W'($urandom);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < RUN_LEN; k++) begin
            #1;
            check_one("a", k, cfg_a(), cmd_a, addr_a, pd_a, rdy_a, oe_a, fin_emr, fin_mr);
            check_one("b", k, cfg_b(), cmd_b, addr_b, pd_b, rdy_b, oe_b, fin_emr, fin_mr);
            if (k == change_at) begin
                emr_op = fin_emr;
                mr_op  = fin_mr;
            end
            if (k == S || k == S + 1) begin
                // R9: late changes must not reach the bus
                emr_op = ~fin_emr;
                mr_op  = ~fin_mr;
            end
            if (k == abort_at) begin
                #2 rst_n = 1'b0;
                #1 check_reset("R10");
                return;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #2 check_reset("R1");
        run_seq(-1);
        run_seq(int'($urandom_range(S + 2, RUN_LEN - 30)));
        run_seq(-1);                        // R10 restart after abort
        run_seq(int'($urandom_range(1, S - 1)));
        run_seq(S + 5);                     // abort between EMRS and MRS
        run_seq(-1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule